// File: doc/BRIEF.md
# Address-Masked Eight-Pin GPIO Peripheral

This block is an eight-pin general-purpose I/O peripheral that sits on an APB-style register bus. Each pin can be an input or an output. Each pin can also be handed to a hardware source that drives its output value and its output enable directly. The pin data register has no single address. The word-address bits of every access to the lower 1 KiB act as a per-pin mask. Software can therefore set, clear or sample any subset of pins in one access, with no read-modify-write sequence.

Each pin also has an interrupt detector. A pin can be set to detect a level or an edge. In edge mode it can watch one edge or both edges. Software sees a raw status, a masked status and a single combined interrupt output. Edge events stay latched until software clears them. Level events follow the pin. Pin inputs are synchronised by two flops before they reach either the read path or the detectors.

Top module: `gpm_top`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` is 0, `irq` is 0 and every pin is a software-controlled input.
- R2: A read at any byte offset 0x000–0x3FC returns, for pin n, 0 when address bit n+2 is 0. Otherwise it returns the data register bit if direction bit n is 1, or the synchronised pin input if direction bit n is 0. An input change becomes visible two clock edges after it is applied.
- R3: A write at any byte offset 0x000–0x3FC updates data register bit n only when address bit n+2 is 1. Every other bit keeps its previous value.
- R4: The direction register at 0x400 reads back as written. A 1 in bit n makes the pin an output. For a software-controlled pin, `pin_oe[n]` equals direction bit n and `pin_out[n]` equals data register bit n.
- R5: The alternate-select register at 0x420 reads back as written. When bit n is 1, `pin_out[n]` follows `hw_out[n]` and `pin_oe[n]` follows `hw_oe[n]`.
- R6: When the sense bit (0x404) is 1, the pin is in level mode. Its raw status bit (0x414) equals the synchronised input if the polarity bit (0x40C) is 1, or its inverse if the polarity bit is 0. The status settles three clock edges after the pin changes, and writes to the clear register do not affect it.
- R7: When the sense bit is 0, the pin is in edge mode. Its raw status bit is set by a rising edge (polarity 1) or a falling edge (polarity 0). It stays set until a 1 is written to that bit of the clear register at 0x41C. Writing 0 to a clear bit has no effect.
- R8: When the both-edges bit (0x408) is 1 on an edge-mode pin, either edge sets the raw status bit, and the polarity bit is ignored.
- R9: The enable register at 0x410 reads back as written. The masked status at 0x418 equals raw status AND enable, and `irq` is 1 exactly when the masked status is nonzero.
- R10: Reads of unmapped offsets, of the clear register, and of any offset from 0x424 upward return 0. Writes to unmapped offsets and to the raw and masked status registers change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 10 | Word address (byte address bits 11:2) |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, 0 when no read is selected |
| pin_in | input | 8 | Asynchronous pin inputs |
| hw_out | input | 8 | Hardware output values for alternate pins |
| hw_oe | input | 8 | Hardware output enables for alternate pins |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest states to reach from the ports are the interrupt combinations. In these, each pin has a different mix of level or edge mode, polarity and both-edges setting, and the raw status has to be compared after exactly one transition. The bench reaches them with random configurations on all eight pins at once. It first settles the pins to a random starting pattern and clears the latched edges. It then applies one random second pattern, so each pin's expected status follows from its own configuration and the two patterns. Directed steps cover what the random loop leaves out: an edge bit outliving the return of its pin, zero bits in a clear write, clear writes to level pins, and writes to read-only or unmapped offsets.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
    localparam int NPIN = 8;
    localparam int WADDR_W = 10;

    // word addresses (byte offset >> 2)
    localparam logic [WADDR_W-1:0] W_DIR   = 10'h100;
    localparam logic [WADDR_W-1:0] W_SENSE = 10'h101;
    localparam logic [WADDR_W-1:0] W_BOTH  = 10'h102;
    localparam logic [WADDR_W-1:0] W_POL   = 10'h103;
    localparam logic [WADDR_W-1:0] W_EN    = 10'h104;
    localparam logic [WADDR_W-1:0] W_RAW   = 10'h105;
    localparam logic [WADDR_W-1:0] W_MIS   = 10'h106;
    localparam logic [WADDR_W-1:0] W_CLR   = 10'h107;
    localparam logic [WADDR_W-1:0] W_ALT   = 10'h108;

    typedef struct packed {
        logic [NPIN-1:0] dout;
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] sense;
        logic [NPIN-1:0] both;
        logic [NPIN-1:0] pol;
        logic [NPIN-1:0] en;
        logic [NPIN-1:0] alt;
    } gpm_cfg_t;
endpackage

// File: rtl/gpm_sync.sv
module gpm_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/gpm_irq.sv
module gpm_irq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] sense,
    input  logic [W-1:0] both,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] clr,
    output logic [W-1:0] raw
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] raw;
    } irq_t;

    irq_t st_d, st_q;
    logic [W-1:0] rise, fall, hit, cond;

    always_comb begin
        st_d = st_q;
        rise = lvl & ~st_q.prev;
        fall = ~lvl & st_q.prev;
        for (int i = 0; i < W; i++) begin
            if (both[i]) hit[i] = rise[i] | fall[i];
            else         hit[i] = pol[i] ? rise[i] : fall[i];
            cond[i] = pol[i] ? lvl[i] : ~lvl[i];
            if (sense[i]) st_d.raw[i] = cond[i];
            else          st_d.raw[i] = (st_q.raw[i] & ~clr[i]) | hit[i];
        end
        st_d.prev = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw = st_q.raw;

    // R7: a latched edge bit survives every cycle without a clear
    p_sticky_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~$past(sense) & $past(st_q.raw) & ~$past(clr) & ~st_q.raw) == '0));

    // R7: an edge bit never sets without a detected edge
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~$past(sense) & ~$past(st_q.raw) & ~$past(hit) & st_q.raw) == '0));
endmodule

// File: rtl/gpm_regs.sv
module gpm_regs
    import gpm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [WADDR_W-1:0] waddr,
    input  logic [NPIN-1:0]    wdata,
    input  logic [NPIN-1:0]    pin_sync,
    input  logic [NPIN-1:0]    raw,
    output gpm_cfg_t           cfg,
    output logic [NPIN-1:0]    clr,
    output logic [NPIN-1:0]    rdata
);
    gpm_cfg_t        cfg_d, cfg_q;
    logic            wr, rd, is_data, mapped;
    logic [NPIN-1:0] mask, rd_mux;

    assign wr      = psel & penable & pwrite;
    assign rd      = psel & ~pwrite;
    assign is_data = (waddr[WADDR_W-1:NPIN] == '0);
    assign mask    = waddr[NPIN-1:0];

    always_comb begin
        cfg_d = cfg_q;
        clr   = '0;
        if (wr) begin
            if (is_data) begin
                cfg_d.dout = (cfg_q.dout & ~mask) | (wdata & mask);
            end else begin
                case (waddr)
                    W_DIR:   cfg_d.dir   = wdata;
                    W_SENSE: cfg_d.sense = wdata;
                    W_BOTH:  cfg_d.both  = wdata;
                    W_POL:   cfg_d.pol   = wdata;
                    W_EN:    cfg_d.en    = wdata;
                    W_CLR:   clr         = wdata;
                    W_ALT:   cfg_d.alt   = wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        mapped = 1'b1;
        rd_mux = '0;
        if (is_data) begin
            rd_mux = ((cfg_q.dir & cfg_q.dout) | (~cfg_q.dir & pin_sync)) & mask;
        end else begin
            case (waddr)
                W_DIR:   rd_mux = cfg_q.dir;
                W_SENSE: rd_mux = cfg_q.sense;
                W_BOTH:  rd_mux = cfg_q.both;
                W_POL:   rd_mux = cfg_q.pol;
                W_EN:    rd_mux = cfg_q.en;
                W_RAW:   rd_mux = raw;
                W_MIS:   rd_mux = raw & cfg_q.en;
                W_ALT:   rd_mux = cfg_q.alt;
                default: mapped = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg   = cfg_q;
    assign rdata = rd ? rd_mux : '0;

    // R3: masked-off data bits hold across a data write
    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && is_data) |=> (((cfg_q.dout ^ $past(cfg_q.dout)) & ~$past(mask)) == '0));

    // R2: a data read never returns a bit whose mask bit is 0
    p_rd_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && is_data) |-> ((rdata & ~mask) == '0));

    // R10: unmapped offsets read as zero
    p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !is_data && !mapped) |-> (rdata == '0));

    // R10: a write to a status offset leaves the configuration unchanged
    p_ro_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (waddr == W_RAW || waddr == W_MIS)) |=> (cfg_q == $past(cfg_q)));
endmodule

// File: rtl/gpm_top.sv
module gpm_top
    import gpm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [9:0]  paddr,
    input  logic [7:0]  pwdata,
    output logic [7:0]  prdata,
    input  logic [7:0]  pin_in,
    input  logic [7:0]  hw_out,
    input  logic [7:0]  hw_oe,
    output logic [7:0]  pin_out,
    output logic [7:0]  pin_oe,
    output logic        irq
);
    gpm_cfg_t        cfg;
    logic [NPIN-1:0] pin_sync, raw, clr;

    gpm_sync #(.W(NPIN)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din (pin_in),
        .dout (pin_sync)
    );

    gpm_regs u_regs (
        .clk (clk),
        .rst_n (rst_n),
        .psel (psel),
        .penable (penable),
        .pwrite (pwrite),
        .waddr (paddr),
        .wdata (pwdata),
        .pin_sync (pin_sync),
        .raw (raw),
        .cfg (cfg),
        .clr (clr),
        .rdata (prdata)
    );

    gpm_irq #(.W(NPIN)) u_irq (
        .clk (clk),
        .rst_n (rst_n),
        .lvl (pin_sync),
        .sense (cfg.sense),
        .both (cfg.both),
        .pol (cfg.pol),
        .clr (clr),
        .raw (raw)
    );

    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_pin
            assign pin_out[g] = cfg.alt[g] ? hw_out[g] : cfg.dout[g];
            assign pin_oe[g]  = cfg.alt[g] ? hw_oe[g]  : cfg.dir[g];
        end
    endgenerate

    assign irq = |(raw & cfg.en);

    // R9: the interrupt line falls only when raw status or enable changed
    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> (raw != $past(raw)) || (cfg.en != $past(cfg.en)));
endmodule

// File: tb/gpm_top_tb_top.sv
module gpm_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [9:0] paddr = '0;
    logic [7:0] pwdata = '0;
    logic [7:0] prdata;
    logic [7:0] pin_in = '0, hw_out = '0, hw_oe = '0;
    logic [7:0] pin_out, pin_oe;
    logic       irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] m_dout = '0, m_dir = '0;

    always #10 clk = ~clk;

    gpm_top dut_i (
        .clk (clk), .rst_n (rst_n), .psel (psel), .penable (penable),
        .pwrite (pwrite), .paddr (paddr), .pwdata (pwdata), .prdata (prdata),
        .pin_in (pin_in), .hw_out (hw_out), .hw_oe (hw_oe),
        .pin_out (pin_out), .pin_oe (pin_oe), .irq (irq)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a[11:2]; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a[11:2]; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_raw(input logic [7:0] sense, input logic [7:0] both,
                                           input logic [7:0] pol, input logic [7:0] p0,
                                           input logic [7:0] p1);
        logic [7:0] lv, rise, fall, hit;
        lv   = sense & ((pol & p1) | (~pol & ~p1));
        rise = ~p0 & p1;
        fall = p0 & ~p1;
        hit  = (both & (rise | fall)) | (~both & ((pol & rise) | (~pol & fall)));
        return lv | (~sense & hit);
    endfunction

    function automatic logic [7:0] exp_data(input logic [7:0] dir, input logic [7:0] dout,
                                            input logic [7:0] pins, input logic [7:0] msk);
        return ((dir & dout) | (~dir & pins)) & msk;
    endfunction

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd;
        logic [7:0] s, b, p, e, p0, p1, er, msk, v;
        void'($urandom(32'd4242));
        settle(4);
        rst_n = 1'b1;
        settle(2);

        // R1: reset state
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        bus_rd(12'h400, rd); chk("R1 dir", rd, 8'h00);
        bus_rd(12'h410, rd); chk("R1 en", rd, 8'h00);
        bus_rd(12'h420, rd); chk("R1 alt", rd, 8'h00);
        bus_rd(12'h414, rd); chk("R1 raw", rd, 8'h00);
        bus_rd(12'h3FC, rd); chk("R1 data", rd, 8'h00);

        // R3/R2: masked writes and reads with all pins as outputs
        bus_wr(12'h400, 8'hFF); m_dir = 8'hFF;
        for (int i = 0; i < 40; i++) begin
            msk = 8'($urandom); v = 8'($urandom);
            bus_wr({2'b00, msk, 2'b00}, v);
            m_dout = (m_dout & ~msk) | (v & msk);
            msk = 8'($urandom);
            bus_rd({2'b00, msk, 2'b00}, rd);
            chk("R3 masked write/read", rd, m_dout & msk);
        end
        // R3 corner: mask 0 changes nothing
        bus_wr(12'h000, ~m_dout);
        bus_rd(12'h3FC, rd); chk("R3 zero mask write", rd, m_dout);
        chk("R4 pin_out", pin_out, m_dout);
        chk("R4 pin_oe", pin_oe, 8'hFF);

        // R2: mixed directions with synchronised inputs
        for (int i = 0; i < 20; i++) begin
            m_dir = 8'($urandom);
            bus_wr(12'h400, m_dir);
            pin_in = 8'($urandom);
            settle(3);
            msk = 8'($urandom);
            bus_rd({2'b00, msk, 2'b00}, rd);
            chk("R2 mixed read", rd, exp_data(m_dir, m_dout, pin_in, msk));
            bus_rd(12'h400, rd); chk("R4 dir readback", rd, m_dir);
        end

        // R5: alternate select
        for (int i = 0; i < 10; i++) begin
            e = 8'($urandom);
            bus_wr(12'h420, e);
            hw_out = 8'($urandom); hw_oe = 8'($urandom);
            #1;
            chk("R5 pin_out", pin_out, (e & hw_out) | (~e & m_dout));
            chk("R5 pin_oe", pin_oe, (e & hw_oe) | (~e & m_dir));
            bus_rd(12'h420, rd); chk("R5 alt readback", rd, e);
        end
        bus_wr(12'h420, 8'h00);

        // R6/R7/R8/R9: random per-pin interrupt configurations
        for (int i = 0; i < 30; i++) begin
            s = 8'($urandom); b = 8'($urandom); p = 8'($urandom); e = 8'($urandom);
            p0 = 8'($urandom); p1 = 8'($urandom);
            pin_in = p0;
            bus_wr(12'h404, s); bus_wr(12'h408, b);
            bus_wr(12'h40C, p); bus_wr(12'h410, e);
            settle(5);
            bus_wr(12'h41C, 8'hFF);
            pin_in = p1;
            settle(5);
            er = exp_raw(s, b, p, p0, p1);
            bus_rd(12'h414, rd); chk("R6/R7/R8 raw", rd, er);
            bus_rd(12'h418, rd); chk("R9 masked", rd, er & e);
            chk("R9 irq", {7'b0, irq}, {7'b0, |(er & e)});
        end

        // R7: edge bit outlives pin return, zero clear bits ignored, one bit clears
        bus_wr(12'h404, 8'h00); bus_wr(12'h408, 8'h00); bus_wr(12'h40C, 8'h01);
        bus_wr(12'h410, 8'h01);
        pin_in = 8'h00; settle(5); bus_wr(12'h41C, 8'hFF);
        pin_in = 8'h01; settle(4); pin_in = 8'h00; settle(5);
        bus_rd(12'h414, rd); chk("R7 sticky edge", rd, 8'h01);
        chk("R9 irq high", {7'b0, irq}, 8'h01);
        bus_wr(12'h41C, 8'hFE);
        bus_rd(12'h414, rd); chk("R7 zero clear bit", rd, 8'h01);
        bus_wr(12'h41C, 8'h01);
        bus_rd(12'h414, rd); chk("R7 clear", rd, 8'h00);
        chk("R9 irq low", {7'b0, irq}, 8'h00);

        // R8: both edges ignores polarity; falling edge with pol=1
        bus_wr(12'h408, 8'h02); bus_wr(12'h40C, 8'h02);
        pin_in = 8'h02; settle(5); bus_wr(12'h41C, 8'hFF);
        pin_in = 8'h00; settle(5);
        bus_rd(12'h414, rd); chk("R8 both edges fall", rd, 8'h02);

        // R6: level bit ignores clear and follows the pin
        bus_wr(12'h404, 8'h04); bus_wr(12'h40C, 8'h04); bus_wr(12'h41C, 8'hFF);
        pin_in = 8'h04; settle(5);
        bus_wr(12'h41C, 8'h04);
        bus_rd(12'h414, rd); chk("R6 level clear ignored", rd, 8'h04);
        pin_in = 8'h00; settle(5);
        bus_rd(12'h414, rd); chk("R6 level follows", rd, 8'h00);

        // R10: read-only, write-only and unmapped offsets
        bus_wr(12'h404, 8'h00);
        bus_rd(12'h410, rd); v = rd;
        bus_wr(12'h414, 8'hFF); bus_wr(12'h418, 8'hFF);
        bus_rd(12'h414, rd); chk("R10 raw write ignored", rd, 8'h00);
        bus_rd(12'h410, rd); chk("R10 en unchanged", rd, v);
        bus_wr(12'h424, 8'hFF); bus_wr(12'hFFC, 8'hFF);
        bus_rd(12'h424, rd); chk("R10 unmapped read", rd, 8'h00);
        bus_rd(12'h41C, rd); chk("R10 clear reads zero", rd, 8'h00);
        bus_rd(12'h420, rd); chk("R10 alt unchanged", rd, 8'h00);
        bus_rd(12'h400, rd); chk("R10 dir unchanged", rd, m_dir);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule